// File: doc/BRIEF.md
# Float-to-Fraction Saturation Override Unit

This unit sits beside a floating-point to fixed-point fraction converter. It looks at the operand and decides whether the converter's arithmetic result can be used. The unit overrides that result when the operand is a NaN, a zero or denormal, or a normal value whose magnitude is 1.0 or more. In those cases it supplies a fixed 32-bit saturation code. When no override applies, it raises `out_in_range` and drives zero on the result bus, so the downstream converter supplies the value.

Each strobe carries one operand. The operand is either single precision, in bits 31:0, or double precision, in bits 63:0. Two selects go with it: one picks the precision and one picks signed or unsigned output. The decision is registered and appears with `out_valid` exactly one cycle after the strobe. Between strobes the outputs hold their last value. The asynchronous active-low reset is released synchronously inside the block.

Top module: `fp2frac_special`

## Requirements
- R1: While reset is active and until the first strobe after it, `out_valid`, `out_result` and `out_in_range` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. With no strobe, `out_result` and `out_in_range` keep their previous values.
- R3: In single mode (`in_double`=0) an operand whose bits 30:23 are all ones and whose bits 22:0 are nonzero is a NaN. It yields result 0x00000000 with `out_in_range`=0.
- R4: An operand whose exponent field is all zeros (zero or denormal) yields result 0x00000000 with `out_in_range`=0, in both precisions.
- R5: A positive operand (sign bit 0) with a biased exponent of at least the bias (127 single, 1023 double) and that is not a NaN yields 0x7FFFFFFF when `in_signed`=1 and 0xFFFFFFFF when `in_signed`=0. `out_in_range` is 0.
- R6: A negative operand (sign bit 1) in the same exponent range yields 0x80000000 when `in_signed`=1 and 0x00000000 when `in_signed`=0. It never wraps. `out_in_range` is 0.
- R7: In double mode (`in_double`=1) the exponent is bits 62:52 and the fraction is bits 51:0. The sign is bit 63. An all-ones exponent with any fraction bit set is a NaN and yields 0x00000000 with `out_in_range`=0.
- R8: In single mode the sign is bit 31, and bits 63:32 have no effect on the outputs.
- R9: A normal operand with a biased exponent between 1 and bias-1 (magnitude below 1.0) gives `out_in_range`=1 and result 0x00000000.
- R10: An infinity (all-ones exponent, zero fraction) saturates according to its sign, as in R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_double | input | 1 | 1: operand is double precision in bits 63:0; 0: single precision in bits 31:0 |
| in_signed | input | 1 | 1: signed fraction target; 0: unsigned |
| in_operand | input | 64 | Floating-point operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 32 | Saturation code or zero |
| out_in_range | output | 1 | 1 when no override applies |

## Verification
The main sweep covers every exponent value of both precisions. Each exponent is crossed with both signs, both signedness selects, and fractions of zero, one LSB, MSB only and all ones. The zero and nonzero fractions at the all-ones exponent separate infinity from NaN. The exponent steps just below and at the bias separate the in-range band from saturation, and exponent zero with a nonzero fraction covers the denormals. Mixed operands separate the two precision decodes: a valid single value sits under a double-mode NaN pattern, and the reverse. Strobe-free cycles with changed inputs show that the outputs hold.

// File: rtl/fpfrac_pkg.sv
package fpfrac_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO    = 3'd0,
    CLS_NAN     = 3'd1,
    CLS_SAT_POS = 3'd2,
    CLS_SAT_NEG = 3'd3,
    CLS_INRANGE = 3'd4
  } fp_cls_e;
endpackage

// File: rtl/fpfrac_rst_sync.sv
module fpfrac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/fpfrac_classify.sv
module fpfrac_classify
  import fpfrac_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W-1:0] man_i,
  output fp_cls_e          cls_o
);
  localparam logic [EXP_W-1:0] BIAS     = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic [EXP_W-1:0] EXP_ONES = '1;

  logic exp_max, exp_zero, man_nz, mag_ge_one;

  assign exp_max    = (exp_i == EXP_ONES);
  assign exp_zero   = (exp_i == '0);
  assign man_nz     = |man_i;
  assign mag_ge_one = (exp_i >= BIAS);

  always_comb begin
    if (exp_max && man_nz)  cls_o = CLS_NAN;
    else if (exp_zero)      cls_o = CLS_ZERO;
    else if (mag_ge_one)    cls_o = sign_i ? CLS_SAT_NEG : CLS_SAT_POS;
    else                    cls_o = CLS_INRANGE;
  end
endmodule

// File: rtl/fpfrac_sat_encode.sv
module fpfrac_sat_encode
  import fpfrac_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  fp_cls_e          cls_i,
  input  logic             signed_i,
  output logic [OUT_W-1:0] value_o,
  output logic             in_range_o
);
  localparam logic [OUT_W-1:0] SMAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] SMIN = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] UMAX = '1;

  always_comb begin
    value_o    = '0;
    in_range_o = 1'b0;
    case (cls_i)
      CLS_SAT_POS: value_o    = signed_i ? SMAX : UMAX;
      CLS_SAT_NEG: value_o    = signed_i ? SMIN : '0;
      CLS_INRANGE: in_range_o = 1'b1;
      default:     value_o    = '0;
    endcase
  end
endmodule

// File: rtl/fp2frac_special.sv
module fp2frac_special
  import fpfrac_pkg::*;
#(
  parameter int OUT_W    = 32,
  parameter int SP_EXP_W = 8,
  parameter int SP_MAN_W = 23,
  parameter int DP_EXP_W = 11,
  parameter int DP_MAN_W = 52
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic                                 in_double,
  input  logic                                 in_signed,
  input  logic [DP_EXP_W+DP_MAN_W:0]           in_operand,
  output logic                                 out_valid,
  output logic [OUT_W-1:0]                     out_result,
  output logic                                 out_in_range
);
  localparam int SP_W = 1 + SP_EXP_W + SP_MAN_W;
  localparam int DP_W = 1 + DP_EXP_W + DP_MAN_W;

  logic rst_sync_n;

  fpfrac_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  // Field extraction for both precisions.
  logic                sp_sign, dp_sign;
  logic [SP_EXP_W-1:0] sp_exp;
  logic [SP_MAN_W-1:0] sp_man;
  logic [DP_EXP_W-1:0] dp_exp;
  logic [DP_MAN_W-1:0] dp_man;

  assign sp_sign = in_operand[SP_W-1];
  assign sp_exp  = in_operand[SP_W-2 -: SP_EXP_W];
  assign sp_man  = in_operand[SP_MAN_W-1:0];
  assign dp_sign = in_operand[DP_W-1];
  assign dp_exp  = in_operand[DP_W-2 -: DP_EXP_W];
  assign dp_man  = in_operand[DP_MAN_W-1:0];

  fp_cls_e sp_cls, dp_cls, sel_cls;

  fpfrac_classify #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_cls_sp (
    .sign_i (sp_sign),
    .exp_i  (sp_exp),
    .man_i  (sp_man),
    .cls_o  (sp_cls)
  );

  fpfrac_classify #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_cls_dp (
    .sign_i (dp_sign),
    .exp_i  (dp_exp),
    .man_i  (dp_man),
    .cls_o  (dp_cls)
  );

  assign sel_cls = in_double ? dp_cls : sp_cls;

  logic [OUT_W-1:0] enc_value;
  logic             enc_in_range;

  fpfrac_sat_encode #(.OUT_W(OUT_W)) u_enc (
    .cls_i      (sel_cls),
    .signed_i   (in_signed),
    .value_o    (enc_value),
    .in_range_o (enc_in_range)
  );

  // Next-state and register processes.
  logic             valid_d, valid_q;
  logic [OUT_W-1:0] result_d, result_q;
  logic             range_d, range_q;
  logic             load_en;

  assign load_en = in_valid;

  always_comb begin
    valid_d  = in_valid;
    result_d = result_q;
    range_d  = range_q;
    if (load_en) begin
      result_d = enc_value;
      range_d  = enc_in_range;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      range_q  <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      result_q <= result_d;
      range_q  <= range_d;
    end
  end

  assign out_valid    = valid_q;
  assign out_result   = result_q;
  assign out_in_range = range_q;

  // Assertions
  logic op_sign;
  assign op_sign = in_double ? in_operand[DP_W-1] : in_operand[SP_W-1];

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);

  assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_result) && $stable(out_in_range)));

  assert_in_range_zero_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_in_range) |-> (out_result == '0));

  assert_unsigned_neg_clamp_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !in_signed && op_sign) |=> (out_result == '0));

  assert_sp_nan_zero_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !in_double && (&in_operand[SP_W-2 -: SP_EXP_W]) && (|in_operand[SP_MAN_W-1:0]))
      |=> (out_result == '0 && !out_in_range));

  assert_dp_nan_zero_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_double && (&in_operand[DP_W-2 -: DP_EXP_W]) && (|in_operand[DP_MAN_W-1:0]))
      |=> (out_result == '0 && !out_in_range));
endmodule

// File: tb/fp2frac_special_tb.sv
module fp2frac_special_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_double;
  logic        in_signed;
  logic [63:0] in_operand;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_in_range;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp2frac_special u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_double    (in_double),
    .in_signed    (in_signed),
    .in_operand   (in_operand),
    .out_valid    (out_valid),
    .out_result   (out_result),
    .out_in_range (out_in_range)
  );

  // Expected {in_range, result} from the requirements.
  function automatic logic [32:0] model(input logic dbl, input logic sg, input logic [63:0] op);
    int unsigned e, emax, bias;
    logic s, fnz;
    if (dbl) begin
      e = op[62:52]; emax = 2047; bias = 1023; s = op[63]; fnz = |op[51:0];
    end else begin
      e = op[30:23]; emax = 255;  bias = 127;  s = op[31]; fnz = |op[22:0];
    end
    if (e == emax && fnz) return 33'h0;
    if (e == 0)           return 33'h0;
    if (e < bias)         return {1'b1, 32'h0};
    if (!s)               return {1'b0, sg ? 32'h7FFF_FFFF : 32'hFFFF_FFFF};
    return {1'b0, sg ? 32'h8000_0000 : 32'h0000_0000};
  endfunction

  function automatic string tag_of(input logic dbl, input logic [63:0] op);
    int unsigned e, emax, bias;
    logic s, fnz;
    if (dbl) begin
      e = op[62:52]; emax = 2047; bias = 1023; s = op[63]; fnz = |op[51:0];
    end else begin
      e = op[30:23]; emax = 255;  bias = 127;  s = op[31]; fnz = |op[22:0];
    end
    if (e == emax && fnz) return dbl ? "R7" : "R3";
    if (e == emax)        return "R10";
    if (e == 0)           return "R4";
    if (e < bias)         return "R9";
    return s ? "R6" : "R5";
  endfunction

  task automatic check(input string tag, input logic [33:0] got, input logic [33:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got valid/range/result=%h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input logic dbl, input logic sg, input logic [63:0] op, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_double = dbl; in_signed = sg; in_operand = op;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_valid, out_in_range, out_result}, {1'b1, model(dbl, sg, op)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [22:0] sp_fr [4];
    logic [51:0] dp_fr [4];
    logic [32:0] held;
    sp_fr[0] = 23'h0; sp_fr[1] = 23'h1; sp_fr[2] = 23'h40_0000; sp_fr[3] = 23'h7F_FFFF;
    dp_fr[0] = 52'h0; dp_fr[1] = 52'h1; dp_fr[2] = 52'h8_0000_0000_0000; dp_fr[3] = 52'hF_FFFF_FFFF_FFFF;

    rst_n = 1'b0; in_valid = 1'b0; in_double = 1'b0; in_signed = 1'b0; in_operand = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {out_valid, out_in_range, out_result}, 34'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {out_valid, out_in_range, out_result}, 34'h0);

    // Single-precision sweep, upper bits filled with varying junk (R8)
    for (int e = 0; e < 256; e++)
      for (int fi = 0; fi < 4; fi++)
        for (int s = 0; s < 2; s++)
          for (int g = 0; g < 2; g++) begin
            logic [63:0] op;
            op = {32'hA5C3_0F96 ^ (32'(e) * 32'h0101_0101), s[0], e[7:0], sp_fr[fi]};
            run(1'b0, g[0], op, tag_of(1'b0, op));
          end

    // Double-precision sweep
    for (int e = 0; e < 2048; e++)
      for (int fi = 0; fi < 4; fi++)
        for (int s = 0; s < 2; s++)
          for (int g = 0; g < 2; g++) begin
            logic [63:0] op;
            op = {s[0], e[10:0], dp_fr[fi]};
            run(1'b1, g[0], op, tag_of(1'b1, op));
          end

    // R8: single mode ignores an upper word that is a double NaN; low word = 1.0
    run(1'b0, 1'b1, {32'h7FF0_0001, 32'h3F80_0000}, "R8");
    check("R8", {out_valid, out_in_range, out_result}, {2'b10, 32'h7FFF_FFFF});
    // R7: same operand in double mode is a NaN
    run(1'b1, 1'b1, {32'h7FF0_0001, 32'h3F80_0000}, "R7");
    check("R7", {out_valid, out_in_range, out_result}, 34'h2_0000_0000);
    // R7: double with only low fraction word bits set at max exponent is NaN
    run(1'b1, 1'b0, 64'h7FF0_0000_0000_0010, "R7");
    // R7: double sign from bit 63 while bit 31 is clear
    run(1'b1, 1'b1, 64'hC000_0000_0000_0000, "R7");
    check("R7", {out_valid, out_in_range, out_result}, {2'b10, 32'h8000_0000});
    // R8: single sign from bit 31 while bit 63 is set
    run(1'b0, 1'b1, 64'h8000_0000_4000_0000, "R8");
    check("R8", {out_valid, out_in_range, out_result}, {2'b10, 32'h7FFF_FFFF});
    // R9 boundary: 0.99999994 in range, 1.0 saturates
    run(1'b0, 1'b1, 64'h0000_0000_3F7F_FFFF, "R9");
    check("R9", {out_valid, out_in_range, out_result}, {2'b11, 32'h0});
    run(1'b0, 1'b0, 64'h0000_0000_BF80_0000, "R6");
    check("R6", {out_valid, out_in_range, out_result}, {2'b10, 32'h0});

    // R2: hold with no strobe while inputs change
    run(1'b0, 1'b1, 64'h0000_0000_4F00_0000, "R2");
    held = {out_in_range, out_result};
    @(negedge clk);
    in_operand = 64'h0000_0000_3E00_0000; in_signed = 1'b0;
    @(negedge clk);
    check("R2", {out_valid, out_in_range, out_result}, {1'b0, held});
    @(negedge clk);
    check("R2", {out_valid, out_in_range, out_result}, {1'b0, held});

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule